// File: doc/BRIEF.md
# Network Event Status and Interrupt Mask Block

This block collects event pulses from the transmit and receive halves of a network controller into two byte-wide sticky status registers. Each status register has a matching mask register. The block drives one active-high interrupt request while any enabled event is pending. It also offers a summary byte that reports the transmit, receive and DMA-completion conditions as active-low flags.

Host software uses a plain byte register bus with an address, a write strobe and a read strobe. To acknowledge events, software writes ones to the same address it reads status from. Any bit written as one is cleared, and bits written as zero keep their value. A DMA engine outside the block pulses `dma_done`. This sets a pending flag that the interrupt mask does not govern.

Top module: `evreg_top`

## Requirements
- R1: After reset, every status bit, both mask registers and the DMA flag are zero, `irq` is low and the summary byte reads 0x07.
- R2: The address map is 0 transmit status, 1 transmit mask, 2 receive status, 3 receive mask, 4 summary. In transmit status, bits 7, 5, 4, 3, 2, 1 and 0 are sticky. A one on the matching `tx_evt` bit sets the bit, and it stays set after the pulse ends.
- R3: Transmit status bit 6 is not stored. It reads back the level of `carrier_in` present at the read strobe, and `tx_evt[6]` has no effect.
- R4: Receive status bits 7, 4, 3, 2, 1 and 0 are sticky and are set by `rx_evt`. Bits 6 and 5 always read zero, whatever `rx_evt` carries.
- R5: A write to a status address clears each bit whose write-data bit is one and leaves the others. Writing 0xFF empties the register.
- R6: When an event pulse and a clearing write reach the same bit in the same cycle, the bit ends up set.
- R7: Mask registers read back what was last written, limited to their writable bits: 7, 5, 3, 2, 1 for transmit (bit 0 is held at zero, as are 6 and 4) and 7, 4, 3, 2, 1, 0 for receive. They hold their value when not written.
- R8: `irq` is high exactly while some transmit status bit AND its mask bit, or some receive status bit AND its mask bit, is one. It follows the registered state after the edge that changes it.
- R9: In the summary byte, bit 0 is zero exactly when an enabled transmit event is pending, bit 1 is zero exactly when an enabled receive event is pending, bit 2 is zero exactly while the DMA flag is set, and bits 7 to 3 read zero.
- R10: A `dma_done` pulse sets the DMA flag. Writing a one to bit 2 of the summary address clears it, and a pulse in the same cycle wins. The flag never drives `irq`.
- R11: `rd_data` takes the addressed value on the clock edge where `rd_en` is high and holds it otherwise. Addresses 5 to 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| tx_evt | input | 8 | Transmit event pulses, one per status bit |
| carrier_in | input | 1 | Live carrier-sense level |
| rx_evt | input | 8 | Receive event pulses, one per status bit |
| dma_done | input | 1 | DMA completion pulse |
| irq | output | 1 | Active-high combined interrupt request |

## Verification
An event pulse or write lands on the clock edge where it is driven. From that edge, `irq` and the summary flags reflect the new state at once. The bench therefore samples `irq` at the following falling edge, and `rd_data` at the same falling edge after the strobe edge. The carrier bit is taken from the level driven during the strobe cycle itself. When reads and writes fall in the same cycle, the reference model is advanced only after it has produced the read value from the state before the edge.

// File: rtl/evreg_pkg.sv
package evreg_pkg;
   localparam int BYTE_W = 8;

   // Kinds of bit positions inside the transmit status byte
   localparam logic [BYTE_W-1:0] TX_STICKY_BITS = 8'hBF;
   localparam logic [BYTE_W-1:0] TX_LIVE_BITS   = 8'h40;
   localparam logic [BYTE_W-1:0] TX_MASK_WR     = 8'hAE;

   // Receive status: bits 6 and 5 unused
   localparam logic [BYTE_W-1:0] RX_STICKY_BITS = 8'h9F;
   localparam logic [BYTE_W-1:0] RX_LIVE_BITS   = 8'h00;
   localparam logic [BYTE_W-1:0] RX_MASK_WR     = 8'h9F;

   // Summary byte flag positions
   localparam int SUM_TX_BIT  = 0;
   localparam int SUM_RX_BIT  = 1;
   localparam int SUM_DMA_BIT = 2;

   typedef enum logic [2:0] {
      REG_TX_STAT = 3'd0,
      REG_TX_MASK = 3'd1,
      REG_RX_STAT = 3'd2,
      REG_RX_MASK = 3'd3,
      REG_SUMMARY = 3'd4
   } evreg_addr_e;
endpackage

// File: rtl/evreg_status.sv
module evreg_status #(
   parameter int W = 8,
   parameter logic [W-1:0] STICKY = '1,
   parameter logic [W-1:0] LIVE   = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_pulse,
   input  logic [W-1:0] live_in,
   input  logic         clr_we,
   input  logic [W-1:0] clr_bits,
   output logic [W-1:0] stat
);
   initial begin : p_param_chk
      assert ((STICKY & LIVE) == '0)
         else $error("evreg_status: a bit cannot be both sticky and live");
   end

   // Inputs that only some bit kinds consume
   logic unused_inputs;
   assign unused_inputs = ^{set_pulse & ~STICKY, live_in & ~LIVE, clr_bits & ~STICKY};

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (LIVE[i]) begin : g_live
         assign stat[i] = live_in[i];
      end else if (STICKY[i]) begin : g_sticky
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= set_pulse[i] | (q & ~(clr_we & clr_bits[i]));
         end
         assign stat[i] = q;

         AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
            set_pulse[i] |=> stat[i]); // R6
         AST_CLR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we && clr_bits[i] && !set_pulse[i]) |=> !stat[i]); // R5
         AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_we && !set_pulse[i]) |=> $stable(stat[i])); // R2
      end else begin : g_unused
         assign stat[i] = 1'b0;
      end
   end
endmodule

// File: rtl/evreg_mask.sv
module evreg_mask #(
   parameter int W = 8,
   parameter logic [W-1:0] WR_BITS = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] mask
);
   logic unused_wdata;
   assign unused_wdata = ^(wdata & ~WR_BITS);

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (WR_BITS[i]) begin : g_rw
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  q <= 1'b0;
            else if (we) q <= wdata[i];
         end
         assign mask[i] = q;
      end else begin : g_zero
         assign mask[i] = 1'b0;
      end
   end

   AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(mask)); // R7
endmodule

// File: rtl/evreg_irq_sum.sv
module evreg_irq_sum
   import evreg_pkg::*;
#(
   parameter int W = BYTE_W
) (
   input  logic [W-1:0] tx_stat,
   input  logic [W-1:0] tx_mask,
   input  logic [W-1:0] rx_stat,
   input  logic [W-1:0] rx_mask,
   input  logic         dma_pend,
   output logic [W-1:0] summary,
   output logic         irq
);
   logic tx_pend, rx_pend;

   assign tx_pend = |(tx_stat & tx_mask);
   assign rx_pend = |(rx_stat & rx_mask);

   always_comb begin
      summary              = '0;
      summary[SUM_TX_BIT]  = ~tx_pend;
      summary[SUM_RX_BIT]  = ~rx_pend;
      summary[SUM_DMA_BIT] = ~dma_pend;
   end

   assign irq = tx_pend | rx_pend;
endmodule

// File: rtl/evreg_top.sv
module evreg_top
   import evreg_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter logic [BYTE_W-1:0] TX_STICKY = TX_STICKY_BITS,
   parameter logic [BYTE_W-1:0] TX_LIVE   = TX_LIVE_BITS,
   parameter logic [BYTE_W-1:0] TX_MWR    = TX_MASK_WR,
   parameter logic [BYTE_W-1:0] RX_STICKY = RX_STICKY_BITS,
   parameter logic [BYTE_W-1:0] RX_MWR    = RX_MASK_WR
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [BYTE_W-1:0] rd_data,
   input  logic [BYTE_W-1:0] tx_evt,
   input  logic              carrier_in,
   input  logic [BYTE_W-1:0] rx_evt,
   input  logic              dma_done,
   output logic              irq
);
   localparam int LIVE_POS = 6;

   initial begin : p_param_chk
      assert (ADDR_W >= 3) else $error("evreg_top: address too narrow for map");
      assert ((TX_MWR & ~TX_STICKY) == '0) else $error("evreg_top: tx mask on non-sticky bit");
      assert ((RX_MWR & ~RX_STICKY) == '0) else $error("evreg_top: rx mask on non-sticky bit");
   end

   // Address decode
   logic hit_txs, hit_txm, hit_rxs, hit_rxm, hit_sum;
   assign hit_txs = (addr == ADDR_W'(REG_TX_STAT));
   assign hit_txm = (addr == ADDR_W'(REG_TX_MASK));
   assign hit_rxs = (addr == ADDR_W'(REG_RX_STAT));
   assign hit_rxm = (addr == ADDR_W'(REG_RX_MASK));
   assign hit_sum = (addr == ADDR_W'(REG_SUMMARY));

   logic [BYTE_W-1:0] tx_stat, rx_stat, tx_mask, rx_mask, summary;
   logic [BYTE_W-1:0] tx_live;

   always_comb begin
      tx_live           = '0;
      tx_live[LIVE_POS] = carrier_in;
   end

   evreg_status #(.W(BYTE_W), .STICKY(TX_STICKY), .LIVE(TX_LIVE)) i_tx_stat (
      .clk(clk), .rst_n(rst_n), .set_pulse(tx_evt), .live_in(tx_live),
      .clr_we(wr_en && hit_txs), .clr_bits(wr_data), .stat(tx_stat));

   evreg_status #(.W(BYTE_W), .STICKY(RX_STICKY), .LIVE('0)) i_rx_stat (
      .clk(clk), .rst_n(rst_n), .set_pulse(rx_evt), .live_in('0),
      .clr_we(wr_en && hit_rxs), .clr_bits(wr_data), .stat(rx_stat));

   evreg_mask #(.W(BYTE_W), .WR_BITS(TX_MWR)) i_tx_mask (
      .clk(clk), .rst_n(rst_n), .we(wr_en && hit_txm), .wdata(wr_data), .mask(tx_mask));

   evreg_mask #(.W(BYTE_W), .WR_BITS(RX_MWR)) i_rx_mask (
      .clk(clk), .rst_n(rst_n), .we(wr_en && hit_rxm), .wdata(wr_data), .mask(rx_mask));

   // DMA completion flag, set wins over clear
   logic dma_pend;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dma_pend <= 1'b0;
      else        dma_pend <= dma_done | (dma_pend & ~(wr_en && hit_sum && wr_data[SUM_DMA_BIT]));
   end

   evreg_irq_sum #(.W(BYTE_W)) i_sum (
      .tx_stat(tx_stat), .tx_mask(tx_mask), .rx_stat(rx_stat), .rx_mask(rx_mask),
      .dma_pend(dma_pend), .summary(summary), .irq(irq));

   // Read path
   logic [BYTE_W-1:0] rd_mux, rd_q;
   always_comb begin
      rd_mux = '0;
      if (hit_txs) rd_mux = tx_stat;
      if (hit_txm) rd_mux = tx_mask;
      if (hit_rxs) rd_mux = rx_stat;
      if (hit_rxm) rd_mux = rx_mask;
      if (hit_sum) rd_mux = summary;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_q <= '0;
      else if (rd_en) rd_q <= rd_mux;
   end
   assign rd_data = rd_q;

   AST_DMA_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      dma_done |=> !summary[SUM_DMA_BIT]); // R10
   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data)); // R11
   AST_TX_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(tx_evt & tx_mask)) && !(wr_en && hit_txm)) |=> irq); // R8
   AST_RX_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(rx_evt & rx_mask)) && !(wr_en && hit_rxm)) |=> irq); // R8
endmodule

// File: tb/test_evreg_top.sv
module test_evreg_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] addr = '0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic [7:0] tx_evt = '0;
   logic       carrier_in = 1'b0;
   logic [7:0] rx_evt = '0;
   logic       dma_done = 1'b0;
   logic       irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // Reference state
   logic [7:0] m_tx = '0, m_rx = '0, m_txm = '0, m_rxm = '0;
   logic       m_dma = 1'b0;
   logic [7:0] m_rd = '0;

   always #10 clk = ~clk;

   evreg_top i_evreg_top (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .tx_evt(tx_evt), .carrier_in(carrier_in),
      .rx_evt(rx_evt), .dma_done(dma_done), .irq(irq));

   function automatic logic [7:0] f_read(input logic [2:0] a, input logic cs);
      case (a)
         3'd0: return m_tx | {1'b0, cs, 6'b0};
         3'd1: return m_txm;
         3'd2: return m_rx;
         3'd3: return m_rxm;
         3'd4: return {5'b0, ~m_dma, ~|(m_rx & m_rxm), ~|(m_tx & m_txm)};
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic f_irq();
      return (|(m_tx & m_txm)) | (|(m_rx & m_rxm));
   endfunction

   task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
      end
   endtask

   // One bus cycle: drive at falling edge, model the rising edge, check at next falling edge
   task automatic cyc(input logic [2:0] a, input bit we, input logic [7:0] wd, input bit re,
                      input logic [7:0] te, input bit cs, input logic [7:0] rev, input bit dd,
                      input string tag);
      addr = a; wr_en = we; wr_data = wd; rd_en = re;
      tx_evt = te; carrier_in = cs; rx_evt = rev; dma_done = dd;
      @(posedge clk);
      if (re) m_rd = f_read(a, cs);
      m_tx = ((m_tx & ~((we && a == 3'd0) ? wd : 8'h00)) | te) & 8'hBF;
      m_rx = ((m_rx & ~((we && a == 3'd2) ? wd : 8'h00)) | rev) & 8'h9F;
      if (we && a == 3'd1) m_txm = wd & 8'hAE;
      if (we && a == 3'd3) m_rxm = wd & 8'h9F;
      m_dma = dd | (m_dma & ~(we && a == 3'd4 && wd[2]));
      @(negedge clk);
      check(irq === f_irq(), {tag, " irq R8"}, {7'b0, irq}, {7'b0, f_irq()});
      check(rd_data === m_rd, {tag, " rd_data R11"}, rd_data, m_rd);
   endtask

   task automatic rd(input logic [2:0] a, input bit cs, input string tag);
      cyc(a, 1'b0, 8'h00, 1'b1, 8'h00, cs, 8'h00, 1'b0, tag);
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d, input string tag);
      cyc(a, 1'b1, d, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, tag);
   endtask

   initial begin : watchdog
      #(20 * 200000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'h5EED1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset values
      check(irq === 1'b0, "R1 irq after reset", {7'b0, irq}, 8'h00);
      for (int a = 0; a < 5; a++) rd(3'(a), 1'b0, "R1");
      check(rd_data === 8'h07, "R1 summary after reset", rd_data, 8'h07);

      // R2: sticky set, unmasked so no irq
      cyc(3'd0, 1'b0, 8'h00, 1'b0, 8'h80, 1'b0, 8'h00, 1'b0, "R2");
      rd(3'd0, 1'b0, "R2");
      check(rd_data === 8'h80, "R2 tx packet-ok sticky", rd_data, 8'h80);
      // R3: tx_evt[6] has no effect; carrier is live
      cyc(3'd0, 1'b0, 8'h00, 1'b0, 8'h40, 1'b0, 8'h00, 1'b0, "R3");
      rd(3'd0, 1'b1, "R3");
      check(rd_data === 8'hC0, "R3 carrier high", rd_data, 8'hC0);
      rd(3'd0, 1'b0, "R3");
      check(rd_data === 8'h80, "R3 carrier low", rd_data, 8'h80);

      // R7: tx mask writable bits, parity bit held low
      wr(3'd1, 8'hFF, "R7");
      check(irq === 1'b1, "R8 masked-in tx event", {7'b0, irq}, 8'h01);
      rd(3'd1, 1'b0, "R7");
      check(rd_data === 8'hAE, "R7 tx mask readback", rd_data, 8'hAE);
      rd(3'd4, 1'b0, "R9");
      check(rd_data === 8'h06, "R9 summary tx pending", rd_data, 8'h06);

      // R4: rx unused bits
      cyc(3'd0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 8'hFF, 1'b0, "R4");
      rd(3'd2, 1'b0, "R4");
      check(rd_data === 8'h9F, "R4 rx status", rd_data, 8'h9F);
      wr(3'd3, 8'hFF, "R7");
      rd(3'd3, 1'b0, "R7");
      check(rd_data === 8'h9F, "R7 rx mask readback", rd_data, 8'h9F);

      // R5: write-one-to-clear
      wr(3'd0, 8'h01, "R5");
      rd(3'd0, 1'b0, "R5");
      check(rd_data === 8'h80, "R5 zero bits untouched", rd_data, 8'h80);
      wr(3'd0, 8'hFF, "R5");
      wr(3'd2, 8'hFF, "R5");
      rd(3'd0, 1'b0, "R5");
      check(rd_data === 8'h00, "R5 full clear", rd_data, 8'h00);
      check(irq === 1'b0, "R8 irq drops after clear", {7'b0, irq}, 8'h00);

      // R6: set wins
      cyc(3'd0, 1'b1, 8'hFF, 1'b0, 8'h04, 1'b0, 8'h00, 1'b0, "R6");
      rd(3'd0, 1'b0, "R6");
      check(rd_data === 8'h04, "R6 set beats clear", rd_data, 8'h04);
      wr(3'd0, 8'hFF, "R6");

      // R10: DMA flag
      cyc(3'd0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, "R10");
      check(irq === 1'b0, "R10 dma no irq", {7'b0, irq}, 8'h00);
      rd(3'd4, 1'b0, "R10");
      check(rd_data === 8'h03, "R10 dma flag low", rd_data, 8'h03);
      cyc(3'd4, 1'b1, 8'h04, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, "R10");
      rd(3'd4, 1'b0, "R10");
      check(rd_data === 8'h03, "R10 pulse beats clear", rd_data, 8'h03);
      wr(3'd4, 8'h04, "R10");
      rd(3'd4, 1'b0, "R10");
      check(rd_data === 8'h07, "R10 cleared", rd_data, 8'h07);

      // R11: unmapped read
      cyc(3'd1, 1'b0, 8'h00, 1'b1, 8'h20, 1'b0, 8'h00, 1'b0, "R11");
      rd(3'd6, 1'b0, "R11");
      check(rd_data === 8'h00, "R11 unmapped reads zero", rd_data, 8'h00);

      // Random traffic against the model (R2 R4 R5 R6 R8 R9 R11)
      for (int k = 0; k < 4000; k++) begin
         logic [2:0] a;
         bit we, re, cs, dd;
         logic [7:0] te, rev, wd;
         a   = 3'($urandom_range(0, 7));
         we  = ($urandom % 3) == 0;
         re  = ($urandom % 2) == 0;
         cs  = ($urandom % 2) == 0;
         dd  = ($urandom % 10) == 0;
         wd  = 8'($urandom);
         te  = (($urandom % 5) == 0) ? 8'(1 << $urandom_range(0, 7)) : 8'h00;
         rev = (($urandom % 5) == 0) ? 8'(1 << $urandom_range(0, 7)) : 8'h00;
         cyc(a, we, wd, re, te, cs, rev, dd, "random R9");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule